// File: doc/BRIEF.md
# Multi-Register Block Transfer Sequencer

This block executes a single multi-register move instruction for a CPU core. The core pulses a start strobe along with several fields: the opcode's direction and size bits, the addressing mode, the index of the base address register, a 16-bit register-select mask and an already resolved start address. The sequencer then walks through the selected registers and moves each one between a 32-bit register file and memory. Memory is reached through a single-beat request port that waits for a ready handshake.

When the mode is predecrement or postincrement, the caller places the current value of the base address register on the start-address input. The sequencer then writes the final address back into that register. Loads are gathered in a private staging buffer and written to the register file only after the last memory read completes. An illegal mode for the chosen direction produces a one-cycle fault pulse and no traffic. A generation-select input decides what value is stored when a predecrement store includes its own base register.

Top module: `blkmove_seq`

## Requirements
- R1: `xfer_load_i`=1 moves memory to registers and 0 moves registers to memory. `xfer_long_i`=1 moves 4 bytes per register (`mem_long_o`=1) and 0 moves 2 bytes (`mem_long_o`=0). Memory is big-endian.
- R2: The following combinations raise `fault_o` for exactly one cycle, in the cycle after start, with no memory request, no register write and no `done_o`: mode 0 or 1 (register direct), mode 3 with a store, and mode 4 with a load.
- R3: Outside predecrement, mask bit i selects register i. Index 0..7 are data registers and 8..15 are address registers. Registers are handled in ascending index order, and the address starts at `eff_addr_i` and grows by the transfer size after each transfer.
- R4: For loads, every memory read completes before the first register-file write. A 16-bit load is sign-extended to 32 bits.
- R5: After a mode-3 load with a non-zero mask, the base address register (index 8+`base_sel_i`) holds the final address. This value replaces any value loaded into it.
- R6: In mode 4 (store), mask bit k selects register 15−k, and the registers are visited from index 15 down to 0. The address is reduced by the transfer size before each store, and the base register ends at the final address.
- R7: In mode 4, when the stored register is the base register itself, the value written is `eff_addr_i` minus one transfer size if `late_gen_i`=1. If `late_gen_i`=0, the value written is `eff_addr_i` unchanged.
- R8: A 16-bit store writes the register's low 16 bits. A request holds its address, size and direction until `mem_ready_i` is seen, and only then does the sequencer move on.
- R9: Modes 2, 5, 6 and 7 never write the base register back. A register loaded in these modes keeps the loaded value.
- R10: An all-zero legal mask gives `done_o` in the cycle after start, with no memory traffic and no register-file write.
- R11: `done_o` is a one-cycle pulse that follows the last register write. A start pulse that arrives while a transfer is running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, sampled when idle |
| xfer_load_i | input | 1 | 1: memory to registers |
| xfer_long_i | input | 1 | 1: 32-bit transfers, 0: 16-bit |
| ea_mode_i | input | 3 | Addressing mode |
| base_sel_i | input | 3 | Base address register number (0..7) |
| reg_mask_i | input | 16 | Register-select mask |
| eff_addr_i | input | 32 | Resolved start address (base register value in modes 3/4) |
| late_gen_i | input | 1 | Base-store value select for mode 4 |
| rf_raddr_o | output | 4 | Register-file read index |
| rf_rdata_i | input | 32 | Register-file read data (combinational) |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 4 | Register-file write index |
| rf_wdata_o | output | 32 | Register-file write data |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | 1: write request |
| mem_long_o | output | 1 | Size qualifier, 1: 4 bytes |
| mem_addr_o | output | 32 | Byte address |
| mem_wdata_o | output | 32 | Write data, right-aligned |
| mem_rdata_i | input | 32 | Read data, right-aligned |
| mem_ready_i | input | 1 | Completes the current request |
| done_o | output | 1 | Transfer complete pulse |
| fault_o | output | 1 | Address fault pulse |

## Verification
A sparse mask such as 0x8181 separates the data bank from the address bank and shows whether the order is ascending. Predecrement stores with asymmetric masks (0xC005) expose a mask-to-register mapping that is not reversed, and they also check the decrement-before-store addressing. Base-register inclusion is tried in predecrement with both generation settings, in postincrement (the final address must win) and in a displacement mode (the loaded value must stay). Memory words with and without bit 15 set tell sign extension apart from zero fill. A random ready pattern, the illegal mode/direction pairs, an empty mask and a start pulse injected mid-transfer cover the handshake, fault, shortcut and busy-ignore cases.

// File: rtl/blkmove_pkg.sv
package blkmove_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_XFER,
      ST_COMMIT,
      ST_WBACK,
      ST_DONE,
      ST_FAULT
   } seq_state_t;

   localparam logic [2:0] AM_DREG    = 3'd0;
   localparam logic [2:0] AM_AREG    = 3'd1;
   localparam logic [2:0] AM_IND     = 3'd2;
   localparam logic [2:0] AM_POSTINC = 3'd3;
   localparam logic [2:0] AM_PREDEC  = 3'd4;

endpackage

// File: rtl/blkmove_legal.sv
module blkmove_legal
   import blkmove_pkg::*;
(
   input  logic [2:0] mode_i,
   input  logic       load_i,
   output logic       legal_o,
   output logic       postinc_o,
   output logic       predec_o
);

   always_comb begin
      postinc_o = (mode_i == AM_POSTINC);
      predec_o  = (mode_i == AM_PREDEC);
      case (mode_i)
         AM_DREG, AM_AREG: legal_o = 1'b0;
         AM_POSTINC:       legal_o = load_i;
         AM_PREDEC:        legal_o = !load_i;
         default:          legal_o = 1'b1;
      endcase
   end

endmodule

// File: rtl/blkmove_pick.sv
module blkmove_pick #(
   parameter int N     = 16,
   parameter int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     vec_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o,
   output logic [N-1:0]     rest_o
);

   always_comb begin
      any_o = |vec_i;
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec_i[i]) idx_o = IDX_W'(i);
      end
      rest_o = vec_i & (vec_i - N'(1));
   end

endmodule

// File: rtl/blkmove_stage.sv
module blkmove_stage #(
   parameter int NREG   = 16,
   parameter int DATA_W = 32,
   parameter int IDX_W  = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              we_i,
   input  logic [IDX_W-1:0]  widx_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [IDX_W-1:0]  ridx_i,
   output logic [DATA_W-1:0] rdata_o
);

   logic [DATA_W-1:0] ent [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_ent
      always_ff @(posedge clk) begin
         if (we_i && widx_i == IDX_W'(g)) ent[g] <= wdata_i;
      end
   end

   assign rdata_o = ent[ridx_i];

endmodule

// File: rtl/blkmove_seq.sv
module blkmove_seq
   import blkmove_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32,
   parameter int NREG   = 16,
   localparam int IDX_W  = $clog2(NREG),
   localparam int BANK   = NREG / 2,
   localparam int BASE_W = $clog2(BANK),
   localparam int HALF_W = DATA_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              xfer_load_i,
   input  logic              xfer_long_i,
   input  logic [2:0]        ea_mode_i,
   input  logic [BASE_W-1:0] base_sel_i,
   input  logic [NREG-1:0]   reg_mask_i,
   input  logic [ADDR_W-1:0] eff_addr_i,
   input  logic              late_gen_i,
   output logic [IDX_W-1:0]  rf_raddr_o,
   input  logic [DATA_W-1:0] rf_rdata_i,
   output logic              rf_we_o,
   output logic [IDX_W-1:0]  rf_waddr_o,
   output logic [DATA_W-1:0] rf_wdata_o,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic              mem_long_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   input  logic [DATA_W-1:0] mem_rdata_i,
   input  logic              mem_ready_i,
   output logic              done_o,
   output logic              fault_o
);

   // elaboration-time parameter checks
   if (NREG != 2 * BANK || (1 << IDX_W) != NREG) begin : g_bad_nreg
      $error("NREG must be a power of two");
   end
   if (ADDR_W != DATA_W) begin : g_bad_addr
      $error("ADDR_W must equal DATA_W so a base register can hold an address");
   end
   if (DATA_W % 16 != 0) begin : g_bad_data
      $error("DATA_W must be a multiple of 16");
   end

   localparam logic [ADDR_W-1:0] STEP_LONG = ADDR_W'(DATA_W / 8);
   localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(DATA_W / 16);

   seq_state_t        state;
   logic              q_load, q_long, q_postinc, q_predec, q_late;
   logic [BASE_W-1:0] q_base;
   logic [NREG-1:0]   pend, commit;
   logic [ADDR_W-1:0] cur, ea0;

   // decode of the incoming request
   logic in_legal, in_postinc, in_predec;
   blkmove_legal u_legal (
      .mode_i    (ea_mode_i),
      .load_i    (xfer_load_i),
      .legal_o   (in_legal),
      .postinc_o (in_postinc),
      .predec_o  (in_predec)
   );

   // next transfer slot
   logic             pk_any;
   logic [IDX_W-1:0] pk_idx;
   logic [NREG-1:0]  pk_rest;
   blkmove_pick #(.N(NREG), .IDX_W(IDX_W)) u_pick_xfer (
      .vec_i  (pend),
      .any_o  (pk_any),
      .idx_o  (pk_idx),
      .rest_o (pk_rest)
   );

   // next commit slot
   logic             cm_any;
   logic [IDX_W-1:0] cm_idx;
   logic [NREG-1:0]  cm_rest;
   blkmove_pick #(.N(NREG), .IDX_W(IDX_W)) u_pick_commit (
      .vec_i  (commit),
      .any_o  (cm_any),
      .idx_o  (cm_idx),
      .rest_o (cm_rest)
   );

   logic [IDX_W-1:0]  reg_sel, base_full;
   logic [ADDR_W-1:0] step, req_addr, addr_next;
   logic [DATA_W-1:0] st_src, ld_val, stg_rdata;
   logic              hs, stg_we;

   assign base_full = {1'b1, q_base};
   assign reg_sel   = q_predec ? (IDX_W'(NREG - 1) - pk_idx) : pk_idx;
   assign step      = q_long ? STEP_LONG : STEP_WORD;
   assign req_addr  = q_predec ? (cur - step) : cur;
   assign addr_next = q_predec ? (cur - step) : (cur + step);
   assign hs        = (state == ST_XFER) && pk_any && mem_ready_i;

   // store source, with base-register substitution in predecrement
   always_comb begin
      st_src = rf_rdata_i;
      if (q_predec && reg_sel == base_full)
         st_src = q_late ? (ea0 - step) : ea0;
   end

   assign ld_val = q_long ? mem_rdata_i
                          : {{HALF_W{mem_rdata_i[HALF_W-1]}}, mem_rdata_i[HALF_W-1:0]};
   assign stg_we = hs && q_load;

   blkmove_stage #(.NREG(NREG), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_stage (
      .clk     (clk),
      .we_i    (stg_we),
      .widx_i  (reg_sel),
      .wdata_i (ld_val),
      .ridx_i  (cm_idx),
      .rdata_o (stg_rdata)
   );

   // memory port
   assign mem_req_o   = (state == ST_XFER) && pk_any;
   assign mem_we_o    = !q_load;
   assign mem_long_o  = q_long;
   assign mem_addr_o  = req_addr;
   assign mem_wdata_o = q_long ? st_src : {{HALF_W{1'b0}}, st_src[HALF_W-1:0]};
   assign rf_raddr_o  = reg_sel;

   // register-file write port
   always_comb begin
      rf_we_o    = 1'b0;
      rf_waddr_o = cm_idx;
      rf_wdata_o = stg_rdata;
      if (state == ST_COMMIT) begin
         rf_we_o = cm_any;
      end else if (state == ST_WBACK) begin
         rf_we_o    = 1'b1;
         rf_waddr_o = base_full;
         rf_wdata_o = cur;
      end
   end

   assign done_o  = (state == ST_DONE);
   assign fault_o = (state == ST_FAULT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         q_load    <= 1'b0;
         q_long    <= 1'b0;
         q_postinc <= 1'b0;
         q_predec  <= 1'b0;
         q_late    <= 1'b0;
         q_base    <= '0;
         pend      <= '0;
         commit    <= '0;
         cur       <= '0;
         ea0       <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start_i) begin
                  q_load    <= xfer_load_i;
                  q_long    <= xfer_long_i;
                  q_postinc <= in_postinc;
                  q_predec  <= in_predec;
                  q_late    <= late_gen_i;
                  q_base    <= base_sel_i;
                  pend      <= reg_mask_i;
                  commit    <= reg_mask_i;
                  cur       <= eff_addr_i;
                  ea0       <= eff_addr_i;
                  if (!in_legal)               state <= ST_FAULT;
                  else if (reg_mask_i == '0)   state <= ST_DONE;
                  else                         state <= ST_XFER;
               end
            end
            ST_XFER: begin
               if (hs) begin
                  pend <= pk_rest;
                  cur  <= addr_next;
                  if (pk_rest == '0) begin
                     if (q_load)        state <= ST_COMMIT;
                     else if (q_predec) state <= ST_WBACK;
                     else               state <= ST_DONE;
                  end
               end
            end
            ST_COMMIT: begin
               commit <= cm_rest;
               if (cm_rest == '0)
                  state <= q_postinc ? ST_WBACK : ST_DONE;
            end
            ST_WBACK: state <= ST_DONE;
            ST_DONE:  state <= ST_IDLE;
            ST_FAULT: state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/blkmove_seq_chk.sv
module blkmove_seq_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              done_o,
   input logic              fault_o,
   input logic              mem_req_o,
   input logic              mem_ready_i,
   input logic              mem_we_o,
   input logic              mem_long_o,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic              rf_we_o
);

   // R2: a fault moves nothing
   p_fault_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> (!mem_req_o && !rf_we_o && !done_o));

   // R2: a fault follows a start pulse
   p_fault_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> $past(start_i));

   // R4: no register write while reads are still outstanding
   p_no_write_in_reads_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> !rf_we_o);

   // R8: a waiting request holds still
   p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ready_i) |=>
         (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_long_o)));

   // R11: done is a single-cycle pulse
   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

endmodule

bind blkmove_seq blkmove_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .done_o      (done_o),
   .fault_o     (fault_o),
   .mem_req_o   (mem_req_o),
   .mem_ready_i (mem_ready_i),
   .mem_we_o    (mem_we_o),
   .mem_long_o  (mem_long_o),
   .mem_addr_o  (mem_addr_o),
   .rf_we_o     (rf_we_o)
);

// File: tb/tb_blkmove_seq.sv
`timescale 1ns/1ps
module tb_blkmove_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, ld = 1'b0, lg = 1'b0, late = 1'b0;
   logic [2:0]  mode = '0, base = '0;
   logic [15:0] mask = '0;
   logic [31:0] ea = '0;
   logic [3:0]  rf_raddr, rf_waddr;
   logic [31:0] rf_rdata, rf_wdata, mem_addr, mem_wdata, mem_rdata;
   logic        rf_we, mem_req, mem_we, mem_long, mem_ready, done, fault;

   always #4 clk = ~clk;

   blkmove_seq dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .xfer_load_i(ld), .xfer_long_i(lg),
      .ea_mode_i(mode), .base_sel_i(base), .reg_mask_i(mask), .eff_addr_i(ea),
      .late_gen_i(late), .rf_raddr_o(rf_raddr), .rf_rdata_i(rf_rdata), .rf_we_o(rf_we),
      .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata), .mem_req_o(mem_req), .mem_we_o(mem_we),
      .mem_long_o(mem_long), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
      .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready), .done_o(done), .fault_o(fault)
   );

   // bench models: register file and big-endian byte memory
   logic [31:0] rf [16];
   logic [7:0]  mem [256];
   logic [31:0] xrf [16];
   logic [7:0]  xmem [256];

   assign rf_rdata = rf[rf_raddr];
   always_comb begin
      if (mem_long)
         mem_rdata = {mem[mem_addr[7:0]], mem[8'(mem_addr[7:0] + 8'd1)],
                      mem[8'(mem_addr[7:0] + 8'd2)], mem[8'(mem_addr[7:0] + 8'd3)]};
      else
         mem_rdata = {16'h0, mem[mem_addr[7:0]], mem[8'(mem_addr[7:0] + 8'd1)]};
   end

   always @(posedge clk) begin
      if (rf_we) rf[rf_waddr] <= rf_wdata;
      if (mem_req && mem_ready && mem_we) begin
         if (mem_long) begin
            mem[mem_addr[7:0]]               <= mem_wdata[31:24];
            mem[8'(mem_addr[7:0] + 8'd1)]    <= mem_wdata[23:16];
            mem[8'(mem_addr[7:0] + 8'd2)]    <= mem_wdata[15:8];
            mem[8'(mem_addr[7:0] + 8'd3)]    <= mem_wdata[7:0];
         end else begin
            mem[mem_addr[7:0]]               <= mem_wdata[15:8];
            mem[8'(mem_addr[7:0] + 8'd1)]    <= mem_wdata[7:0];
         end
      end
   end

   // ready generator
   logic        rdy_rand = 1'b0;
   logic [7:0]  lfsr = 8'hA5;
   always @(negedge clk) begin
      lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_ready <= rdy_rand ? lfsr[0] : 1'b1;
   end

   // traffic monitor
   logic [7:0] alog [32];
   int         nlog, nviol, nwr;
   bit         wrote;
   always @(posedge clk) begin
      if (mem_req && mem_ready) begin
         if (wrote) nviol++;
         if (nlog < 32) alog[nlog] = mem_addr[7:0];
         nlog++;
      end
      if (rf_we) begin
         wrote = 1'b1;
         nwr++;
      end
   end

   int checks = 0, failures = 0;

   task automatic check(input bit ok, input string rq, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s: %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   function automatic logic [31:0] xrd(input logic [31:0] a, input bit l);
      logic [7:0] b;
      b = a[7:0];
      if (l) return {xmem[b], xmem[8'(b + 8'd1)], xmem[8'(b + 8'd2)], xmem[8'(b + 8'd3)]};
      return {{16{xmem[b][7]}}, xmem[b], xmem[8'(b + 8'd1)]};
   endfunction

   task automatic xwr(input logic [31:0] a, input logic [31:0] v, input bit l);
      logic [7:0] b;
      b = a[7:0];
      if (l) begin
         xmem[b] = v[31:24]; xmem[8'(b + 8'd1)] = v[23:16];
         xmem[8'(b + 8'd2)] = v[15:8]; xmem[8'(b + 8'd3)] = v[7:0];
      end else begin
         xmem[b] = v[15:8]; xmem[8'(b + 8'd1)] = v[7:0];
      end
   endtask

   // one instruction: drive, wait, compare against the requirement model
   task automatic run_op(input bit l_ld, input bit l_lg, input logic [2:0] l_md,
                         input logic [2:0] l_bs, input logic [15:0] l_mk,
                         input logic [31:0] l_ea, input bit l_late, input bit interfere,
                         input string rq);
      logic [31:0] tmp [16];
      logic [7:0]  xlog [32];
      logic [31:0] a, sz, v;
      int          xn, cyc, bad;
      bit          legal, got_done, got_fault;
      if (l_md == 3'd3 || l_md == 3'd4) rf[8 + l_bs] = l_ea;
      for (int i = 0; i < 16; i++) xrf[i] = rf[i];
      for (int i = 0; i < 256; i++) xmem[i] = mem[i];
      legal = !(l_md == 3'd0 || l_md == 3'd1 || (l_md == 3'd3 && !l_ld) ||
                (l_md == 3'd4 && l_ld));
      sz = l_lg ? 32'd4 : 32'd2;
      a  = l_ea;
      xn = 0;
      if (legal && l_mk != 16'h0) begin
         if (l_ld) begin
            for (int i = 0; i < 16; i++) if (l_mk[i]) begin
               tmp[i] = xrd(a, l_lg); xlog[xn] = a[7:0]; xn++; a = a + sz;
            end
            for (int i = 0; i < 16; i++) if (l_mk[i]) xrf[i] = tmp[i];
            if (l_md == 3'd3) xrf[8 + l_bs] = a;
         end else if (l_md == 3'd4) begin
            for (int k = 0; k < 16; k++) if (l_mk[k]) begin
               a = a - sz;
               v = ((15 - k) == 8 + l_bs) ? (l_late ? l_ea - sz : l_ea) : xrf[15 - k];
               xwr(a, v, l_lg); xlog[xn] = a[7:0]; xn++;
            end
            xrf[8 + l_bs] = a;
         end else begin
            for (int i = 0; i < 16; i++) if (l_mk[i]) begin
               xwr(a, xrf[i], l_lg); xlog[xn] = a[7:0]; xn++; a = a + sz;
            end
         end
      end
      nlog = 0; nviol = 0; nwr = 0; wrote = 1'b0;
      ld = l_ld; lg = l_lg; mode = l_md; base = l_bs; mask = l_mk; ea = l_ea;
      late = l_late; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 1;
      while (!done && !fault && cyc < 400) begin
         if (interfere && cyc == 2) begin
            ld = !l_ld; mode = 3'd2; mask = 16'hFFFF; ea = 32'h0; start = 1'b1;
         end
         @(negedge clk);
         start = 1'b0;
         cyc++;
      end
      got_done = done; got_fault = fault;
      if (legal) check(got_done && !got_fault, "R11", "done outcome", {got_fault, got_done}, 2'b01);
      else       check(got_fault && !got_done, "R2", "fault outcome", {got_fault, got_done}, 2'b10);
      if (l_mk == 16'h0 && legal) check(cyc == 1, "R10", "empty-mask latency", cyc, 1);
      if (!legal || l_mk == 16'h0) check(nlog == 0 && nwr == 0, legal ? "R10" : "R2",
                                          "traffic count", nlog + nwr, 0);
      bad = -1;
      for (int i = 15; i >= 0; i--) if (rf[i] !== xrf[i]) bad = i;
      check(bad < 0, rq, "register file", (bad < 0) ? 32'h0 : rf[bad],
            (bad < 0) ? 32'h0 : xrf[bad]);
      bad = -1;
      for (int i = 255; i >= 0; i--) if (mem[i] !== xmem[i]) bad = i;
      check(bad < 0, rq, "memory bytes", (bad < 0) ? 32'h0 : 32'(mem[bad]),
            (bad < 0) ? 32'h0 : 32'(xmem[bad]));
      bad = (nlog == xn) ? -1 : 99;
      if (bad < 0) for (int i = xn - 1; i >= 0; i--) if (alog[i] !== xlog[i]) bad = i;
      check(bad < 0, rq, "address sequence", (bad < 0 || bad == 99) ? nlog : alog[bad],
            (bad < 0 || bad == 99) ? xn : xlog[bad]);
      if (l_ld && legal) check(nviol == 0, "R4", "writes before last read", nviol, 0);
      @(negedge clk);
      check(!done, "R11", "done pulse width", done, 0);
   endtask

   task automatic t_reset();
      check(!done && !fault && !mem_req && !rf_we, "R11", "idle outputs after reset",
            {done, fault, mem_req, rf_we}, 0);
   endtask

   task automatic t_load_long_ind();   run_op(1, 1, 3'd2, 3'd2, 16'h8181, 32'h40, 0, 0, "R1"); endtask
   task automatic t_load_word_post();  rdy_rand = 1; run_op(1, 0, 3'd3, 3'd3, 16'h0C03, 32'h60, 0, 0, "R5"); rdy_rand = 0; endtask
   task automatic t_store_long_disp(); run_op(0, 1, 3'd5, 3'd1, 16'h0F0F, 32'h80, 0, 0, "R3"); endtask
   task automatic t_store_word_abs();  rdy_rand = 1; run_op(0, 0, 3'd7, 3'd0, 16'hF0F0, 32'hA0, 0, 0, "R8"); rdy_rand = 0; endtask
   task automatic t_predec_late();     run_op(0, 1, 3'd4, 3'd5, 16'hC005, 32'hF0, 1, 0, "R6"); endtask
   task automatic t_predec_early();    run_op(0, 0, 3'd4, 3'd5, 16'hC005, 32'hE0, 0, 0, "R7"); endtask
   task automatic t_predec_late_word();run_op(0, 0, 3'd4, 3'd6, 16'h0202, 32'hD0, 1, 0, "R7"); endtask
   task automatic t_load_disp_base();  run_op(1, 1, 3'd6, 3'd2, 16'h0401, 32'h20, 0, 0, "R9"); endtask
   task automatic t_faults();
      run_op(1, 1, 3'd0, 3'd0, 16'h00FF, 32'h10, 0, 0, "R2");
      run_op(0, 1, 3'd1, 3'd0, 16'h00FF, 32'h10, 0, 0, "R2");
      run_op(0, 1, 3'd3, 3'd4, 16'h00FF, 32'h10, 0, 0, "R2");
      run_op(1, 0, 3'd4, 3'd4, 16'h00FF, 32'h10, 0, 0, "R2");
   endtask
   task automatic t_empty_mask();      run_op(1, 1, 3'd3, 3'd1, 16'h0000, 32'h70, 0, 0, "R10"); endtask
   task automatic t_busy_start();      rdy_rand = 1; run_op(0, 1, 3'd2, 3'd0, 16'h00F3, 32'h30, 0, 1, "R11"); rdy_rand = 0; endtask

   bit wd_hit = 1'b0;
   initial begin
      #(8 * 150000);
      wd_hit = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog: run did not finish actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) rf[i] = 32'h1000_0000 * i + 32'h0000_8000 + 32'h111 * i;
      for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
      mem[8'h60] = 8'h9A; mem[8'h62] = 8'h12; mem[8'h64] = 8'hF0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_load_long_ind();
      t_load_word_post();
      t_store_long_disp();
      t_store_word_abs();
      t_predec_late();
      t_predec_early();
      t_predec_late_word();
      t_load_disp_base();
      t_faults();
      t_empty_mask();
      t_busy_start();
      if (!wd_hit) begin
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule